// File: doc/BRIEF.md
# Conversion Sequencer with Limit Compare

This block is the digital control side of a successive-approximation converter. After a start trigger it waits a fixed number of bus cycles to synchronize, then counts a set number of conversion-clock ticks. That number depends on the resolution, on whether a long sampling window is selected, and on whether this conversion is a single one (or the first of a continuous run) or a later conversion in a run. The conversion clock is a one-cycle enable pulse in the bus-clock domain. It is formed from one of four selectable tick sources and then divided by 1, 2, 4 or 8. The divider and the prescaler restart at the beginning of every counting phase.

When counting ends, the block takes a right-justified sample word from a stand-in for the analog converter and masks it to the selected resolution. An optional limit compare then decides whether the result is kept. The compare adds the result to the two's complement of the compare value, with both masked to the resolution, and reads the carry out of that sum. In upper-limit mode a result passes when it is greater than or equal to the limit. In lower-limit mode it passes when it is strictly less than the limit. A result that passes is loaded into the result register and raises the complete flag. A result that fails is discarded and leaves the flag unchanged. In continuous mode the next conversion begins at once in either case.

The controller has four states. ST_IDLE goes to ST_SYNC on start. ST_SYNC goes to ST_CONV after SYNC_CYCLES bus cycles. ST_CONV goes to ST_CMP on the last conversion tick. ST_CMP goes back to ST_CONV when continuous mode is on and otherwise to ST_IDLE. A start pulse in any state restarts the sequence in ST_SYNC. The configuration inputs are latched on start, except for the continuous bit, which is read in ST_CMP.

Top module: `adc_seq_cmp`

## Requirements
- R1: After reset, busy and done are low and result is zero.
- R2: A single conversion, or the first of a continuous run, raises busy-low and completion exactly SYNC_CYCLES + N*D*P + 1 clock cycles after the clock edge that samples start. N is 20 (8-bit, short sample), 23 (10/12-bit, short), 40 (8-bit, long) or 43 (10/12-bit, long). D is the divide ratio and P is the source period.
- R3: A later conversion in a continuous run takes N*D*P + 1 cycles from the previous completion. N is 17 (8-bit, short), 20 (10/12-bit, short), 37 (8-bit, long) or 40 (10/12-bit, long).
- R4: Clock source select: 00 gives a tick on every bus cycle, 01 on every second cycle, 10 on every fourth cycle, and 11 whenever the alt_tick input is high.
- R5: Divide select 00, 01, 10 and 11 gives a conversion-clock ratio of 1, 2, 4 and 8 source ticks.
- R6: Mode 00 is 8-bit, 01 is 10-bit, and 10 or 11 is 12-bit. The result holds the low-order bits of sample at that width, and all higher bits are zero.
- R7: With compare disabled, every completion loads result and sets done.
- R8: With compare enabled and cmp_upper=1, a completion sets done only if result >= compare value.
- R9: With compare enabled and cmp_upper=0, a completion sets done only if result < compare value.
- R10: A result that fails the compare leaves result and done unchanged, and a continuous run keeps converting.
- R11: done clears on the cycle after rd_ack or start, unless a passing completion occurs in that same cycle after rd_ack.
- R12: busy rises in the cycle after start, stays high across a continuous run, and falls at the completion where cont is low.
- R13: In 8-bit and 10-bit modes, only the low 8 or 10 bits of the compare value take part in the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start or restart a conversion sequence |
| rd_ack | input | 1 | Result read; clears done |
| clk_sel | input | 2 | Conversion clock source select |
| div_sel | input | 2 | Conversion clock divide select |
| mode | input | 2 | Resolution select |
| long_smp | input | 1 | Long sampling window |
| cont | input | 1 | Continuous conversion |
| cmp_en | input | 1 | Limit compare enable |
| cmp_upper | input | 1 | 1: upper limit (>=), 0: lower limit (<) |
| cmp_val | input | 12 | Compare value |
| alt_tick | input | 1 | Alternate source tick enable |
| sample | input | 12 | Right-justified word from the converter model |
| result | output | 12 | Last accepted result |
| done | output | 1 | Conversion complete flag |
| busy | output | 1 | Sequence in progress |

## Verification
The timing vectors sweep all four cycle counts of the first conversion and the products of source period and divide ratio. A wrong length entry, a wrong prescaler or a wrong divider mask therefore each shifts completion by a distinct number of cycles. Compare vectors sit exactly on and one below a limit in each direction, which separates >= from > and < from <=. Other vectors pair a compare value whose high bits would flip the outcome with a sample whose high bits must be masked, which exposes a missing mask on either operand. Continuous runs with short and long sampling measure the first and the second completion separately. A failing continuous run and a stalled alternate tick source show that discarded results and idle sources hold the outputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W = 12;
    localparam int SEL_W = 2;
    localparam int DIV_W = 2;
    localparam int LEN_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_CONV,
        ST_CMP
    } seq_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic [DIV_W-1:0] div_sel;
        logic [1:0]       mode;
        logic             long_smp;
        logic             cmp_en;
        logic             cmp_upper;
        logic [RES_W-1:0] cmp_val;
    } seq_cfg_t;

    // conversion-clock ticks for one conversion
    function automatic logic [LEN_W-1:0] conv_len(input logic [1:0] mode,
                                                  input logic long_smp,
                                                  input logic first);
        logic narrow;
        logic [LEN_W-1:0] len;
        narrow = (mode == 2'b00);
        unique case ({first, long_smp})
            2'b10:   len = narrow ? LEN_W'(20) : LEN_W'(23);
            2'b11:   len = narrow ? LEN_W'(40) : LEN_W'(43);
            2'b00:   len = narrow ? LEN_W'(17) : LEN_W'(20);
            default: len = narrow ? LEN_W'(37) : LEN_W'(40);
        endcase
        return len;
    endfunction

    function automatic logic [RES_W-1:0] res_mask(input logic [1:0] mode);
        logic [RES_W-1:0] m;
        unique case (mode)
            2'b00:   m = RES_W'(12'h0FF);
            2'b01:   m = RES_W'(12'h3FF);
            default: m = RES_W'(12'hFFF);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             alt_tick,
    output logic             conv_tick
);
    localparam int DCNT_W = (1 << DIV_W) - 1;
    localparam int PRE_W  = 2;

    logic [PRE_W-1:0]  pre_cnt;
    logic [DCNT_W-1:0] div_cnt;
    logic [DCNT_W-1:0] div_mask;
    logic              src_tick;

    always_ff @(posedge clk) begin
        if (rst || !run) pre_cnt <= '0;
        else             pre_cnt <= pre_cnt + PRE_W'(1);
    end

    always_comb begin
        unique case (src_sel)
            2'b00:   src_tick = 1'b1;
            2'b01:   src_tick = pre_cnt[0];
            2'b10:   src_tick = &pre_cnt;
            default: src_tick = alt_tick;
        endcase
    end

    always_comb begin
        for (int i = 0; i < DCNT_W; i++)
            div_mask[i] = (i < int'(div_sel));
    end

    always_ff @(posedge clk) begin
        if (rst || !run)   div_cnt <= '0;
        else if (src_tick) div_cnt <= div_cnt + DCNT_W'(1);
    end

    assign conv_tick = run && src_tick && ((div_cnt & div_mask) == div_mask);

endmodule

// File: rtl/adc_limit_cmp.sv
module adc_limit_cmp #(
    parameter int W = 12
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] limit,
    input  logic         en,
    input  logic         upper,
    output logic         pass
);
    logic [W:0] sum;
    logic       no_borrow;

    // value + (~limit + 1): carry out set when value >= limit
    assign sum       = {1'b0, value} + {1'b0, ~limit} + (W+1)'(1);
    assign no_borrow = sum[W];
    assign pass      = !en || (upper ? no_borrow : !no_borrow);

endmodule

// File: rtl/adc_seq_cmp.sv
module adc_seq_cmp
    import adc_seq_pkg::*;
#(
    parameter int SYNC_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_ack,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [1:0]       mode,
    input  logic             long_smp,
    input  logic             cont,
    input  logic             cmp_en,
    input  logic             cmp_upper,
    input  logic [RES_W-1:0] cmp_val,
    input  logic             alt_tick,
    input  logic [RES_W-1:0] sample,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             busy
);
    localparam int SYNC_W = $clog2(SYNC_CYCLES + 1);
    localparam int CNT_W  = (SYNC_W > LEN_W) ? SYNC_W : LEN_W;

    seq_state_t        state_q, state_d;
    seq_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              first_q;
    logic              conv_tick;
    logic              pass;
    logic [RES_W-1:0]  mask, sample_m, limit_m;
    logic [LEN_W-1:0]  len;
    logic              last_tick, sync_done;

    assign mask      = res_mask(cfg_q.mode);
    assign sample_m  = sample & mask;
    assign limit_m   = cfg_q.cmp_val & mask;
    assign len       = conv_len(cfg_q.mode, cfg_q.long_smp, first_q);
    assign last_tick = conv_tick && (cnt_q == CNT_W'(len) - CNT_W'(1));
    assign sync_done = (cnt_q == CNT_W'(SYNC_CYCLES - 1));

    adc_clk_div u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == ST_CONV),
        .src_sel   (cfg_q.clk_sel),
        .div_sel   (cfg_q.div_sel),
        .alt_tick  (alt_tick),
        .conv_tick (conv_tick)
    );

    adc_limit_cmp #(.W(RES_W)) u_cmp (
        .value (sample_m),
        .limit (limit_m),
        .en    (cfg_q.cmp_en),
        .upper (cfg_q.cmp_upper),
        .pass  (pass)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SYNC;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SYNC: if (sync_done) state_d = ST_CONV;
                ST_CONV: if (last_tick) state_d = ST_CMP;
                ST_CMP:  state_d = cont ? ST_CONV : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // counters, configuration and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            if (start) begin
                cfg_q   <= '{clk_sel: clk_sel, div_sel: div_sel, mode: mode,
                             long_smp: long_smp, cmp_en: cmp_en,
                             cmp_upper: cmp_upper, cmp_val: cmp_val};
                first_q <= 1'b1;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_SYNC: cnt_q <= sync_done ? '0 : cnt_q + CNT_W'(1);
                    ST_CONV: if (conv_tick) cnt_q <= cnt_q + CNT_W'(1);
                    ST_CMP: begin
                        cnt_q   <= '0;
                        first_q <= 1'b0;
                        if (pass) result <= sample_m;
                    end
                    default: cnt_q <= '0;
                endcase
            end

            if (start)                         done <= 1'b0;
            else if (state_q == ST_CMP && pass) done <= 1'b1;
            else if (rd_ack)                   done <= 1'b0;
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_cmp_chk.sv
module adc_seq_cmp_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             rd_ack,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result
);
    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (!rst && rst_d)
            assert_reset_clear_R1: assert (!busy && !done && result == '0)
                else $error("outputs not cleared by reset");
    end

    assert_start_busy_R12: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done));

    assert_busy_rise_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_from_busy_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (result != $past(result)) |-> done);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !busy) |=> !done);

endmodule

bind adc_seq_cmp adc_seq_cmp_chk #(.RES_W(adc_seq_pkg::RES_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .rd_ack (rd_ack),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/adc_seq_cmp_test.sv
`timescale 1ns/1ps
module adc_seq_cmp_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, rd_ack = 1'b0;
    logic [1:0]  clk_sel = 2'b00, div_sel = 2'b00, mode = 2'b00;
    logic        long_smp = 1'b0, cont = 1'b0, cmp_en = 1'b0, cmp_upper = 1'b0;
    logic [11:0] cmp_val = 12'h000, sample = 12'h000;
    logic        alt_tick = 1'b1;
    logic [11:0] result;
    logic        done, busy;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    adc_seq_cmp uut (
        .clk(clk), .rst(rst), .start(start), .rd_ack(rd_ack),
        .clk_sel(clk_sel), .div_sel(div_sel), .mode(mode),
        .long_smp(long_smp), .cont(cont), .cmp_en(cmp_en),
        .cmp_upper(cmp_upper), .cmp_val(cmp_val), .alt_tick(alt_tick),
        .sample(sample), .result(result), .done(done), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [1:0]  dv;
        logic [1:0]  md;
        logic        ls;
        logic        ce;
        logic        cu;
        logic [11:0] cv;
        logic [11:0] smp;
        logic [9:0]  cyc;
        logic        edone;
        logic [11:0] eres;
        logic [3:0]  ttag;
        logic [3:0]  rtag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 12'h000, 12'hABC, 10'd29,  1'b1, 12'hABC, 4'd2, 4'd7},
        '{2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'h000, 12'hABC, 10'd26,  1'b1, 12'h0BC, 4'd2, 4'd6},
        '{2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 12'h000, 12'hFFF, 10'd49,  1'b1, 12'h3FF, 4'd2, 4'd6},
        '{2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 12'h000, 12'h155, 10'd46,  1'b1, 12'h055, 4'd2, 4'd6},
        '{2'd1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 12'h000, 12'h123, 10'd52,  1'b1, 12'h123, 4'd4, 4'd7},
        '{2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h0FF, 10'd166, 1'b1, 12'h0FF, 4'd5, 4'd6},
        '{2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h200, 10'd98,  1'b1, 12'h200, 4'd5, 4'd6},
        '{2'd0, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 12'h000, 12'h7FF, 10'd350, 1'b1, 12'h7FF, 4'd5, 4'd7},
        '{2'd3, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 12'h000, 12'h001, 10'd29,  1'b1, 12'h001, 4'd4, 4'd7},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 12'h800, 12'h800, 10'd29,  1'b1, 12'h800, 4'd2, 4'd8},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 12'h800, 12'h7FF, 10'd29,  1'b0, 12'h800, 4'd2, 4'd10},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 12'h800, 12'h7FF, 10'd29,  1'b1, 12'h7FF, 4'd2, 4'd9},
        '{2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 12'h800, 12'h800, 10'd29,  1'b0, 12'h7FF, 4'd2, 4'd10},
        '{2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 12'h140, 12'h041, 10'd26,  1'b1, 12'h041, 4'd2, 4'd13},
        '{2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 12'h140, 12'hF3F, 10'd26,  1'b1, 12'h03F, 4'd2, 4'd13},
        '{2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 12'hC00, 12'h000, 10'd29,  1'b1, 12'h000, 4'd2, 4'd13}
    };

    function automatic string tag_name(input int t);
        case (t)
            2:  return "R2";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (busy && n < 2000);
    endtask

    // continuous run: first and second completion times, then stop
    task automatic run_cont(input logic [1:0] md, input logic ls,
                            input int exp1, input int exp2);
        int t1, t2, n;
        logic cleared;
        t1 = 0; t2 = 0; cleared = 1'b0;
        clk_sel = 2'b00; div_sel = 2'b00; mode = md; long_smp = ls;
        cmp_en = 1'b0; cont = 1'b1; sample = 12'h3C5;
        kick();
        for (int c = 1; c <= 300; c++) begin
            @(posedge clk);
            @(negedge clk);
            rd_ack = 1'b0;
            if (t1 != 0 && c == t1 + 1) cleared = ~done;
            if (done) begin
                if (t1 == 0) begin
                    t1 = c;
                    rd_ack = 1'b1;
                end else if (c > t1 + 1) begin
                    t2 = c;
                    break;
                end
            end
        end
        rd_ack = 1'b0;
        check("R2 first continuous completion", 32'(t1), 32'(exp1));
        check("R3 subsequent continuous completion", 32'(t2), 32'(exp2));
        check("R11 rd_ack clears done", 32'(cleared), 32'd1);
        check("R12 busy held in continuous run", 32'(busy), 32'd1);
        cont = 1'b0;
        wait_idle(n);
        check("R12 busy drops after cont cleared", 32'(n), 32'(exp2 - exp1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n;
        logic [11:0] held;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 result after reset", 32'(result), 32'd0);

        // table walk: single conversions
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            clk_sel = VECS[i].sel; div_sel = VECS[i].dv; mode = VECS[i].md;
            long_smp = VECS[i].ls; cmp_en = VECS[i].ce; cmp_upper = VECS[i].cu;
            cmp_val = VECS[i].cv; sample = VECS[i].smp; cont = 1'b0;
            kick();
            wait_idle(n);
            check(tag_name(int'(VECS[i].ttag)), 32'(n), 32'(VECS[i].cyc));
            check(tag_name(int'(VECS[i].rtag)), 32'(done), 32'(VECS[i].edone));
            check(tag_name(int'(VECS[i].rtag)), 32'(result), 32'(VECS[i].eres));
        end

        // R11: read acknowledge clears done, result kept
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        check("R11 done after rd_ack", 32'(done), 32'd0);
        check("R11 result kept after rd_ack", 32'(result), 32'h000);

        // R11/R12: start clears done and raises busy
        clk_sel = 2'b00; div_sel = 2'b00; mode = 2'b10; long_smp = 1'b0;
        cmp_en = 1'b0; sample = 12'h5A5;
        kick();
        wait_idle(n);
        check("R7 done set", 32'(done), 32'd1);
        kick();
        check("R11 start clears done", 32'(done), 32'd0);
        check("R12 busy after start", 32'(busy), 32'd1);
        wait_idle(n);
        check("R2 restart completion time", 32'(n), 32'd29);

        // R3: continuous, short and long sampling
        run_cont(2'b00, 1'b0, 26, 44);
        run_cont(2'b10, 1'b1, 49, 90);

        // R10: failing compare in continuous mode keeps running
        held = result;
        @(negedge clk);
        mode = 2'b10; long_smp = 1'b0; cmp_en = 1'b1; cmp_upper = 1'b1;
        cmp_val = 12'hFFF; sample = 12'h000; cont = 1'b1;
        kick();
        repeat (150) @(negedge clk);
        check("R10 done stays low on failing run", 32'(done), 32'd0);
        check("R10 busy stays high on failing run", 32'(busy), 32'd1);
        check("R10 result unchanged on failing run", 32'(result), 32'(held));
        cont = 1'b0;
        wait_idle(n);
        check("R12 failing run stops", 32'(busy), 32'd0);

        // R4: alternate tick source stalls until alt_tick rises
        @(negedge clk);
        clk_sel = 2'b11; div_sel = 2'b00; cmp_en = 1'b0; alt_tick = 1'b0;
        sample = 12'h0AA;
        kick();
        repeat (99) @(negedge clk);
        check("R4 stalled without alt_tick", 32'(busy), 32'd1);
        alt_tick = 1'b1;
        wait_idle(n);
        check("R4 completion after alt_tick", 32'(n), 32'd24);
        check("R4 result after alt_tick", 32'(result), 32'h0AA);

        summary();
    end

endmodule